// File: doc/BRIEF.md
# PLL Rate Table Lookup

This block holds a small table of supported PLL output rates. Each row stores a rate together with the divider settings that produce it: a reference divider, an output divider, a feedback multiplier and a loop bandwidth value. Software or a sequencer loads rows through a simple write port. A row whose rate is zero ends the table. Every row before the first zero-rate row is valid, and nothing at or after it is considered.

Two lookups are offered, both started with a one-cycle `start_i` pulse and finished with a one-cycle `done_o` pulse. The exact lookup returns the first row whose rate equals the request, or reports a miss. The round-down lookup assumes the rows are stored in descending rate order. It returns the first row whose rate does not exceed the request. When every valid rate is above the request, it clamps to the last valid row, which holds the smallest rate. The block examines one row per clock.

Top module: `rate_table_lookup`

## Requirements
- R1: After reset every row holds zero. A write with `wr_en_i` high stores all five fields into row `wr_idx_i` on the rising clock edge. `tbl_len_o` equals the number of rows before the first row whose rate is zero, or DEPTH when no row has a zero rate.
- R2: With `op_i`=0 (exact), the result is the lowest-indexed valid row whose rate equals `req_rate_i`. It comes with `hit_o`=1 and all five fields of that row.
- R3: An exact lookup that matches no valid row gives `hit_o`=0 and all result fields zero. Rows at or after the terminating zero-rate row never match.
- R4: With `op_i`=1 (round-down), the result is the lowest-indexed valid row whose rate is less than or equal to `req_rate_i`. It comes with `hit_o`=1 and that row's fields.
- R5: A round-down lookup in which every valid rate exceeds the request returns the last valid row with `hit_o`=0.
- R6: With an empty table (`tbl_len_o`=0), either lookup finishes with `done_o` one cycle after start, `hit_o`=0 and all fields zero.
- R7: A start sampled while idle makes `busy_o` high from the next cycle until the cycle `done_o` pulses, and `done_o` is high for exactly one cycle. A `start_i` sampled while busy is ignored: the running lookup keeps its request and operation.
- R8: When the result is decided at row i, `done_o` rises i+1 clock edges after the edge that sampled start. A miss or clamp over a table of length L takes L edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table row |
| wr_idx_i | input | $clog2(DEPTH) | Row written |
| wr_rate_i | input | 32 | Rate field of written row (0 terminates table) |
| wr_ref_div_i | input | 6 | Reference divider of written row |
| wr_out_div_i | input | 4 | Output divider of written row |
| wr_fb_mul_i | input | 13 | Feedback multiplier of written row |
| wr_bw_i | input | 12 | Bandwidth value of written row |
| start_i | input | 1 | Begin a lookup (sampled when idle) |
| op_i | input | 1 | 0 = exact lookup, 1 = round-down query |
| req_rate_i | input | 32 | Requested rate |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| hit_o | output | 1 | Exact match found / row at or below request found |
| rate_o | output | 32 | Result rate |
| ref_div_o | output | 6 | Result reference divider |
| out_div_o | output | 4 | Result output divider |
| fb_mul_o | output | 13 | Result feedback multiplier |
| bw_o | output | 12 | Result bandwidth value |
| tbl_len_o | output | $clog2(DEPTH+1) | Number of valid rows |

## Verification
The hardest case to reach is a start pulse that arrives mid-scan. It must be ignored, and that only shows if the first lookup runs for at least two rows. The bench therefore injects a second start, with an inverted request and operation, only when its model predicts a latency of two or more. It then checks that the result still belongs to the first request. Tables whose rows after the terminator hold nonzero garbage, a full table with no terminator, and tables with duplicate rates cover the boundary and first-match cases. Requests are drawn from stored rates, from the gaps between them, and from above the maximum and below the minimum.

// File: rtl/pll_tbl_pkg.sv
package pll_tbl_pkg;
  localparam int RATE_W = 32;
  localparam int REF_W  = 6;
  localparam int OUT_W  = 4;
  localparam int FB_W   = 13;
  localparam int BW_W   = 12;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [REF_W-1:0]  ref_div;
    logic [OUT_W-1:0]  out_div;
    logic [FB_W-1:0]   fb_mul;
    logic [BW_W-1:0]   bw;
  } pll_entry_t;

  typedef enum logic {
    OP_EXACT = 1'b0,
    OP_ROUND = 1'b1
  } lookup_op_e;
endpackage

// File: rtl/rate_store.sv
module rate_store
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  pll_entry_t       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output pll_entry_t       rd_data_o,
  output logic [DEPTH-1:0] zero_o
);
  pll_entry_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g))) mem_q[g] <= wr_data_i;
    end
    assign zero_o[g] = (mem_q[g].rate == '0);
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/rate_len_find.sv
module rate_len_find #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] zero_i,
  output logic [LEN_W-1:0] len_o
);
  // first zero-rate row terminates the table
  always_comb begin
    len_o = LEN_W'(DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (zero_i[i]) len_o = LEN_W'(i);
    end
  end
endmodule

// File: rtl/rate_scan.sv
module rate_scan
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [RATE_W-1:0] req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  pll_entry_t        entry_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output pll_entry_t        result_o
);
  logic              busy_q, done_q, hit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;
  lookup_op_e        op_q;
  logic [RATE_W-1:0] req_q;
  pll_entry_t        res_q;
  logic              found, last;

  assign found = (op_q == OP_ROUND) ? (entry_i.rate <= req_q) : (entry_i.rate == req_q);
  assign last  = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      op_q   <= OP_EXACT;
      req_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          len_q  <= len_i;
          op_q   <= lookup_op_e'(op_i);
          req_q  <= req_i;
        end
      end else if (len_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        hit_q  <= 1'b0;
        res_q  <= '0;
      end else if (found) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        hit_q  <= 1'b1;
        res_q  <= entry_i;
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        hit_q  <= 1'b0;
        res_q  <= (op_q == OP_ROUND) ? entry_i : '0;  // clamp to smallest rate
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign rd_idx_o = idx_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign hit_o    = hit_q;
  assign result_o = res_q;

  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(req_q));
  assert_exact_eq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o && op_q == OP_EXACT) |-> result_o.rate == req_q);
  assert_miss_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o && op_q == OP_EXACT) |-> result_o == '0);
  assert_round_le_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o && op_q == OP_ROUND) |-> result_o.rate <= req_q);
  assert_idx_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && len_q != '0) |-> LEN_W'(idx_q) < len_q);
endmodule

// File: rtl/rate_table_lookup.sv
module rate_table_lookup
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [RATE_W-1:0] wr_rate_i,
  input  logic [REF_W-1:0]  wr_ref_div_i,
  input  logic [OUT_W-1:0]  wr_out_div_i,
  input  logic [FB_W-1:0]   wr_fb_mul_i,
  input  logic [BW_W-1:0]   wr_bw_i,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [RATE_W-1:0] req_rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [OUT_W-1:0]  out_div_o,
  output logic [FB_W-1:0]   fb_mul_o,
  output logic [BW_W-1:0]   bw_o,
  output logic [LEN_W-1:0]  tbl_len_o
);
  pll_entry_t       wr_data, rd_data, result;
  logic [IDX_W-1:0] rd_idx;
  logic [DEPTH-1:0] zero_vec;

  assign wr_data = '{rate: wr_rate_i, ref_div: wr_ref_div_i, out_div: wr_out_div_i,
                     fb_mul: wr_fb_mul_i, bw: wr_bw_i};

  rate_store #(.DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i,
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .zero_o(zero_vec)
  );

  rate_len_find #(.DEPTH(DEPTH)) i_len (.zero_i(zero_vec), .len_o(tbl_len_o));

  rate_scan #(.DEPTH(DEPTH)) i_scan (
    .clk_i, .rst_ni, .start_i, .op_i, .req_i(req_rate_i), .len_i(tbl_len_o),
    .entry_i(rd_data), .rd_idx_o(rd_idx), .busy_o, .done_o, .hit_o, .result_o(result)
  );

  assign rate_o    = result.rate;
  assign ref_div_o = result.ref_div;
  assign out_div_o = result.out_div;
  assign fb_mul_o  = result.fb_mul;
  assign bw_o      = result.bw;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(start_i)) |=> !done_o);
endmodule

// File: tb/test_rate_table_lookup.sv
`timescale 1ns/1ps
module test_rate_table_lookup;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_rate = '0;
  logic [5:0]  wr_ref = '0;
  logic [3:0]  wr_out = '0;
  logic [12:0] wr_fb = '0;
  logic [11:0] wr_bw = '0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [31:0] req = '0;
  logic        busy, done, hit;
  logic [31:0] rate;
  logic [5:0]  ref_div;
  logic [3:0]  out_div;
  logic [12:0] fb_mul;
  logic [11:0] bw;
  logic [4:0]  tbl_len;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] sh_rate [DEPTH];
  logic [5:0]  sh_ref  [DEPTH];
  logic [3:0]  sh_out  [DEPTH];
  logic [12:0] sh_fb   [DEPTH];
  logic [11:0] sh_bw   [DEPTH];

  rate_table_lookup #(.DEPTH(DEPTH)) i_rate_table_lookup (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_rate_i(wr_rate), .wr_ref_div_i(wr_ref), .wr_out_div_i(wr_out),
    .wr_fb_mul_i(wr_fb), .wr_bw_i(wr_bw), .start_i(start), .op_i(op),
    .req_rate_i(req), .busy_o(busy), .done_o(done), .hit_o(hit), .rate_o(rate),
    .ref_div_o(ref_div), .out_div_o(out_div), .fb_mul_o(fb_mul), .bw_o(bw),
    .tbl_len_o(tbl_len)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_row(input int idx, input logic [31:0] r);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_rate = r;
    wr_ref = 6'($urandom); wr_out = 4'($urandom); wr_fb = 13'($urandom); wr_bw = 12'($urandom);
    sh_rate[idx] = r; sh_ref[idx] = wr_ref; sh_out[idx] = wr_out; sh_fb[idx] = wr_fb; sh_bw[idx] = wr_bw;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int model_len();
    for (int i = 0; i < DEPTH; i++) if (sh_rate[i] == 0) return i;
    return DEPTH;
  endfunction

  // Load descending table of length n; rows past the terminator hold garbage.
  task automatic fill_desc(input int n);
    logic [31:0] r = 32'h4000_0000 + 32'($urandom % 32'h1000_0000);
    for (int i = 0; i < DEPTH; i++) begin
      if (i < n) begin wr_row(i, r); r = r - 32'd1 - 32'($urandom % 5000); end
      else if (i == n) wr_row(i, 32'd0);
      else wr_row(i, 32'h1 + 32'($urandom % 32'h7fff_ffff));
    end
    chk("R1", "tbl_len", 32'(tbl_len), 32'(model_len()));
  endtask

  task automatic run_op(input logic o, input logic [31:0] rq, input bit disturb);
    int n = model_len(), idx = -1, lat, got = 0;
    bit h = 0;
    string tag;
    for (int i = 0; i < n; i++) begin
      if (o ? (sh_rate[i] <= rq) : (sh_rate[i] == rq)) begin idx = i; h = 1; break; end
    end
    if (n == 0) begin lat = 1; tag = "R6"; end
    else if (h) begin lat = idx + 1; tag = o ? "R4" : "R2"; end
    else begin lat = n; if (o) idx = n - 1; tag = o ? "R5" : "R3"; end
    if (disturb && lat < 2) disturb = 0;
    @(negedge clk);
    start = 1'b1; op = o; req = rq;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      chk("R7", "busy after start", 32'(busy), 32'd1);
      start = 1'b1; op = ~o; req = ~rq;  // must be ignored
    end
    do begin
      @(posedge clk); got++;
      @(negedge clk); start = 1'b0;
    end while (!done && got < 40);
    chk("R8", "latency", 32'(got), 32'(lat));
    chk(tag, "hit", 32'(hit), 32'(h));
    chk(tag, "rate", rate, idx >= 0 ? sh_rate[idx] : 32'd0);
    chk(tag, "ref_div", 32'(ref_div), idx >= 0 ? 32'(sh_ref[idx]) : 32'd0);
    chk(tag, "out_div", 32'(out_div), idx >= 0 ? 32'(sh_out[idx]) : 32'd0);
    chk(tag, "fb_mul", 32'(fb_mul), idx >= 0 ? 32'(sh_fb[idx]) : 32'd0);
    chk(tag, "bw", 32'(bw), idx >= 0 ? 32'(sh_bw[idx]) : 32'd0);
    chk("R7", "busy at done", 32'(busy), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      sh_rate[i] = 0; sh_ref[i] = 0; sh_out[i] = 0; sh_fb[i] = 0; sh_bw[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "reset len", 32'(tbl_len), 32'd0);
    chk("R7", "reset busy", 32'(busy), 32'd0);
    chk("R7", "reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // empty table
    run_op(1'b0, 32'd1000, 0);
    run_op(1'b1, 32'd1000, 0);
    // full table, no terminator: clamp at last row
    fill_desc(DEPTH);
    run_op(1'b1, 32'd5, 0);
    run_op(1'b0, sh_rate[DEPTH-1], 1);
    run_op(1'b1, 32'hffff_ffff, 0);
    // duplicates: first index wins
    for (int i = 0; i < 6; i++) wr_row(i, 32'd700 - 32'(i / 2) * 32'd100);
    wr_row(6, 32'd0);
    chk("R1", "tbl_len dup", 32'(tbl_len), 32'd6);
    run_op(1'b0, 32'd600, 1);
    run_op(1'b1, 32'd650, 1);
    // rate present only past the terminator must miss
    wr_row(8, 32'd12345);
    run_op(1'b0, 32'd12345, 1);
    // single row
    wr_row(1, 32'd0);
    chk("R1", "tbl_len one", 32'(tbl_len), 32'd1);
    run_op(1'b1, 32'd10, 0);
    run_op(1'b0, 32'd700, 0);
    // random tables
    for (int t = 0; t < 60; t++) begin
      int n = int'($urandom % (DEPTH + 1));
      fill_desc(n);
      for (int k = 0; k < 6; k++) begin
        logic [31:0] rq;
        int sel = int'($urandom % 4);
        if (n == 0) rq = $urandom;
        else if (sel == 0) rq = sh_rate[$urandom % n];
        else if (sel == 1) rq = sh_rate[$urandom % n] - 32'd1;
        else if (sel == 2) rq = sh_rate[n-1] - 32'($urandom % 100) - 32'd1;
        else rq = sh_rate[0] + 32'($urandom % 100);
        run_op(1'($urandom), rq, bit'($urandom));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule